// File: doc/BRIEF.md
# Dual-Channel Output Compare Unit

This block compares two 16-bit compare registers against a free-running counter value that arrives on an input port. When the counter reaches a register's value, the block can invert the level of one of two output pins. Each channel has a run bit, a pin enable, an output level, a match flag and an interrupt enable. All of them sit in one 16-bit control register, and a simple write/read port gives access to it and to the two compare registers.

A mode bit selects how the second pin reacts. In split mode, each pin follows its own compare register. In pulse mode, the second pin inverts on matches from either register, so the two register values set the rising and falling edges of a pulse. When both registers match on the same cycle, the second pin inverts only once.

Each pin level is held in a two-state machine with the states `LVL_LO` and `LVL_HI`. There are three transitions:
- **preset**: a control-register write loads the written level, from either state.
- **toggle**: an enabled match flips `LVL_LO` to `LVL_HI` or `LVL_HI` to `LVL_LO`.
- **hold**: with neither of the above, the state stays as it is.

Top module: `ocu_pair`

## Requirements
- R1: With the mode bit (control bit 12) at 0, pin 0's level inverts on a channel-0 match and pin 1's level inverts on a channel-1 match; a match on one channel leaves the other pin's level unchanged.
- R2: With the mode bit at 1, pin 0 inverts only on a channel-0 match, while pin 1 inverts on a match of either channel.
- R3: With the mode bit at 1, a match of both channels in the same cycle inverts pin 1 exactly once.
- R4: Pin enable bits (control bits 11:10, bit 10 for channel 0) select each pin: 0 drives the general-purpose input `gp_i` to the pin and freezes that channel's level; 1 drives the compare level.
- R5: Addresses are control = 0, compare 0 = 1, compare 1 = 2. All fields and compare registers reset to 0, and bits 15:13, 3:2 and address 3 read as 0.
- R6: Control bits 9:8 (bit 8 for channel 0) read back the current output levels. A control write loads them from the written data on the next clock, and the write takes priority over a match in that cycle.
- R7: A run bit of 0 (control bits 1:0, bit 0 for channel 0) suppresses that channel's matches, so its level and flag stay unchanged.
- R8: A match sets the channel's flag (control bits 7:6, bit 6 for channel 0). Writing 0 to a flag clears it and writing 1 keeps it; a match in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when some channel has both its flag and its interrupt enable (control bits 5:4, bit 4 for channel 0) set.
- R10: A match occurs only in the cycle in which the counter input changes to the register value. A counter that holds that value gives no further match.
- R11: A compare register written while its channel runs is used for the first comparison after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | 16 | Free-running counter value |
| gp_i | input | 2 | General-purpose levels for pins not in compare mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data (combinational) |
| pin_o | output | 2 | Pin levels, bit 0 is pin 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is pulse mode with both compare registers holding the same value. The counter must arrive at that value while both channels run and pin 1 is enabled, and a single wrong extra inversion looks identical to no inversion. The bench sets up this case directly and checks for one inversion. The random phase draws compare values and counter steps from a small range, so coincident matches, held counter values and control writes that collide with matches all occur often.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int ADDR_W    = 2;
    localparam int A_CTRL    = 0;
    localparam int A_CMP0    = 1;
    localparam int A_CMP1    = 2;
    localparam int B_MODE    = 12;
    localparam int B_PEN     = 10;
    localparam int B_LVL     = 8;
    localparam int B_FLAG    = 6;
    localparam int B_IEN     = 4;
    localparam int B_RUN     = 0;

    typedef enum logic {
        LVL_LO = 1'b0,
        LVL_HI = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/ocu_match.sv
module ocu_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt_i,
    input  logic [W-1:0] cnt_prev_i,
    input  logic         prev_ok_i,
    input  logic         run_i,
    input  logic         cmp_we,
    input  logic [W-1:0] cmp_wdata,
    output logic [W-1:0] cmp_o,
    output logic         match_o
);
    logic [W-1:0] cmp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    assign cmp_o   = cmp_q;
    assign match_o = run_i && prev_ok_i && (cnt_i == cmp_q) && (cnt_i != cnt_prev_i);

    AST_SINGLE_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !(match_o && cnt_i == $past(cnt_i)));  // R10
endmodule

// File: rtl/ocu_level_fsm.sv
module ocu_level_fsm
    import ocu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic preset_en,
    input  logic preset_val,
    input  logic toggle_en,
    output logic level_o
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LVL_LO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (preset_en) begin
            state_d = preset_val ? LVL_HI : LVL_LO;
        end else if (toggle_en) begin
            unique case (state_q)
                LVL_LO: state_d = LVL_HI;
                LVL_HI: state_d = LVL_LO;
            endcase
        end
    end

    assign level_o = (state_q == LVL_HI);

    AST_PRESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en |=> level_o == $past(preset_val));  // R6
    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_en && !preset_en) |=> level_o != $past(level_o));  // R1
endmodule

// File: rtl/ocu_pair.sv
module ocu_pair
    import ocu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      cnt_i,
    input  logic [1:0]        gp_i,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W-1:0]      rd_data,
    output logic [1:0]        pin_o,
    output logic              irq_o
);
    localparam int NCH = 2;

    logic           mode_q;
    logic [NCH-1:0] pen_q, flag_q, ien_q, run_q;
    logic [W-1:0]   cnt_prev_q;
    logic           prev_ok_q;
    logic [NCH-1:0] match, tog, lvl;
    logic [W-1:0]   cmp [NCH];
    logic           ctrl_we;

    assign ctrl_we = wr_en && (wr_addr == ADDR_W'(A_CTRL));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q     <= 1'b0;
            pen_q      <= '0;
            flag_q     <= '0;
            ien_q      <= '0;
            run_q      <= '0;
            cnt_prev_q <= '0;
            prev_ok_q  <= 1'b0;
        end else begin
            cnt_prev_q <= cnt_i;
            prev_ok_q  <= 1'b1;
            if (ctrl_we) begin
                mode_q <= wr_data[B_MODE];
                pen_q  <= wr_data[B_PEN +: NCH];
                ien_q  <= wr_data[B_IEN +: NCH];
                run_q  <= wr_data[B_RUN +: NCH];
                flag_q <= (flag_q & wr_data[B_FLAG +: NCH]) | match;
            end else begin
                flag_q <= flag_q | match;
            end
        end
    end

    assign tog[0] = pen_q[0] && match[0];
    assign tog[1] = pen_q[1] && (mode_q ? (match[0] || match[1]) : match[1]);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        ocu_match #(.W(W)) u_match (
            .clk        (clk),
            .rst_n      (rst_n),
            .cnt_i      (cnt_i),
            .cnt_prev_i (cnt_prev_q),
            .prev_ok_i  (prev_ok_q),
            .run_i      (run_q[c]),
            .cmp_we     (wr_en && (wr_addr == ADDR_W'(A_CMP0 + c))),
            .cmp_wdata  (wr_data),
            .cmp_o      (cmp[c]),
            .match_o    (match[c])
        );
        ocu_level_fsm u_lvl (
            .clk        (clk),
            .rst_n      (rst_n),
            .preset_en  (ctrl_we),
            .preset_val (wr_data[B_LVL + c]),
            .toggle_en  (tog[c]),
            .level_o    (lvl[c])
        );
        assign pin_o[c] = pen_q[c] ? lvl[c] : gp_i[c];
    end

    assign irq_o = |(flag_q & ien_q);

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(A_CTRL): begin
                rd_data[B_MODE]        = mode_q;
                rd_data[B_PEN +: NCH]  = pen_q;
                rd_data[B_LVL +: NCH]  = lvl;
                rd_data[B_FLAG +: NCH] = flag_q;
                rd_data[B_IEN +: NCH]  = ien_q;
                rd_data[B_RUN +: NCH]  = run_q;
            end
            ADDR_W'(A_CMP0): rd_data = cmp[0];
            ADDR_W'(A_CMP1): rd_data = cmp[1];
            default:         rd_data = '0;
        endcase
    end

    AST_SPLIT_ISOLATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && !ctrl_we && !match[1]) |=> lvl[1] == $past(lvl[1]));  // R1
    AST_PULSE_EITHER: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && pen_q[1] && match[0] && !ctrl_we) |=> lvl[1] != $past(lvl[1]));  // R2
    AST_COINCIDE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && pen_q[1] && match[0] && match[1] && !ctrl_we) |=> lvl[1] != $past(lvl[1]));  // R3
    AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!pen_q[0] && !ctrl_we) |=> lvl[0] == $past(lvl[0]));  // R4
    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q[0] && !ctrl_we) |=> (lvl[0] == $past(lvl[0])) && (flag_q[0] == $past(flag_q[0])));  // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        match[1] |=> flag_q[1]);  // R8
endmodule

// File: tb/tb_ocu_pair.sv
module tb_ocu_pair;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_i = '0;
    logic [1:0]  gp_i = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [1:0]  pin_o;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // reference model state
    bit        m_mode;
    bit [1:0]  m_pen, m_lvl, m_flag, m_ien, m_run;
    bit [15:0] m_cmp [2];
    bit [15:0] m_prev;
    bit        m_pok;

    always #2 clk = ~clk;

    ocu_pair dut (.*);

    function automatic bit [15:0] exp_read(input bit [1:0] a);
        if (a == 2'd0) return {3'b0, m_mode, m_pen, m_lvl, m_flag, m_ien, 2'b0, m_run};
        if (a == 2'd1) return m_cmp[0];
        if (a == 2'd2) return m_cmp[1];
        return 16'h0;
    endfunction

    function automatic bit [1:0] exp_pins(input bit [1:0] gp);
        return (m_pen & m_lvl) | (~m_pen & gp);
    endfunction

    task automatic model_reset();
        m_mode = 0; m_pen = 0; m_lvl = 0; m_flag = 0; m_ien = 0; m_run = 0;
        m_cmp[0] = 0; m_cmp[1] = 0; m_prev = 0; m_pok = 0;
    endtask

    task automatic check(input string tag, input string what, input bit [15:0] act, input bit [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input bit [15:0] cnt, input bit [1:0] gp, input bit we,
                        input bit [1:0] wa, input bit [15:0] wd, input bit [1:0] ra, input string tag);
        bit [1:0] m, t;
        @(negedge clk);
        cnt_i = cnt; gp_i = gp; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
        for (int c = 0; c < 2; c++)
            m[c] = m_run[c] && m_pok && (cnt == m_cmp[c]) && (cnt != m_prev);
        t[0] = m[0];
        t[1] = m_mode ? (m[0] | m[1]) : m[1];
        @(posedge clk);
        #1;
        if (we && wa == 2'd0) begin
            m_lvl  = wd[9:8];
            m_flag = (m_flag & wd[7:6]) | m;
            m_mode = wd[12]; m_pen = wd[11:10]; m_ien = wd[5:4]; m_run = wd[1:0];
        end else begin
            m_lvl  = m_lvl ^ (m_pen & t);
            m_flag = m_flag | m;
        end
        if (we && wa == 2'd1) m_cmp[0] = wd;
        if (we && wa == 2'd2) m_cmp[1] = wd;
        m_prev = cnt; m_pok = 1;
        check(tag, "pins", {14'b0, pin_o}, {14'b0, exp_pins(gp)});
        check(tag, "irq", {15'b0, irq_o}, {15'b0, |(m_flag & m_ien)});
        check(tag, "rd_data", rd_data, exp_read(ra));
    endtask

    task automatic idle(input bit [15:0] cnt, input string tag);
        step(cnt, 2'b00, 0, 0, 0, 0, tag);
    endtask

    task automatic wr(input bit [15:0] cnt, input bit [1:0] a, input bit [15:0] d, input string tag);
        step(cnt, 2'b00, 1, a, d, 0, tag);
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 200000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit [15:0] c;
        void'($urandom(32'd9137));
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        check("R5", "reset ctrl", rd_data, 16'h0);
        check("R5", "reset pins", {14'b0, pin_o}, 16'h0);
        rst_n = 1'b1;
        step(0, 2'b10, 0, 0, 0, 2'd1, "R5");
        step(0, 2'b01, 0, 0, 0, 2'd2, "R5");
        step(0, 2'b11, 0, 0, 0, 2'd3, "R4");

        // R1 split mode, both channels running and enabled
        wr(0, 2'd1, 16'd5, "R1");
        wr(0, 2'd2, 16'd8, "R1");
        wr(0, 2'd0, 16'h0C33, "R1");
        for (int i = 1; i <= 10; i++) idle(16'(i), "R1");
        // R10 counter holds value: single match
        wr(11, 2'd1, 16'd20, "R11");
        idle(20, "R11");
        repeat (4) idle(20, "R10");
        idle(21, "R10");
        // R3 pulse mode, coincident matches
        wr(21, 2'd1, 16'd30, "R3");
        wr(21, 2'd2, 16'd30, "R3");
        wr(21, 2'd0, 16'h1C33, "R3");
        idle(30, "R3");
        idle(31, "R3");
        // R2 pulse edges from separate registers
        wr(31, 2'd2, 16'd40, "R2");
        idle(35, "R2");
        idle(30, "R2");
        idle(40, "R2");
        idle(41, "R2");
        // R6 preset wins over a match in same cycle
        wr(41, 2'd1, 16'd50, "R6");
        step(50, 2'b00, 1, 2'd0, 16'h1F33, 2'd0, "R6");
        idle(51, "R6");
        // R8 clear with 0, keep with 1, match wins
        wr(52, 2'd0, 16'h1F73, "R8");
        wr(53, 2'd1, 16'd54, "R8");
        step(54, 2'b00, 1, 2'd0, 16'h1F33, 2'd0, "R8");
        // R9 interrupt enables
        wr(55, 2'd0, 16'h1F23, "R9");
        wr(56, 2'd0, 16'h1F03, "R9");
        // R7 channels stopped
        wr(56, 2'd0, 16'h0C00, "R7");
        idle(54, "R7");
        idle(40, "R7");
        // R4 pins disabled follow gp, levels frozen
        wr(40, 2'd0, 16'h0003, "R4");
        step(54, 2'b01, 0, 0, 0, 0, "R4");
        step(40, 2'b10, 0, 0, 0, 0, "R4");
        step(41, 2'b11, 0, 0, 0, 2'd0, "R4");

        // random phase
        c = 0;
        for (int i = 0; i < 4000; i++) begin
            int r = int'($urandom_range(0, 99));
            bit [15:0] d;
            c = (c + 16'($urandom_range(0, 2))) & 16'h003F;
            if (r < 4) begin
                d = 16'($urandom) & 16'h1FF3;
                d[11:10] = 2'b11;
                if ($urandom_range(0, 3) == 0) d[11:10] = 2'($urandom);
                d[1:0] = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b11;
                step(c, 2'($urandom), 1, 2'd0, d, 2'($urandom), m_mode ? "R2" : "R1");
            end else if (r < 8) begin
                step(c, 2'($urandom), 1, 2'($urandom_range(1, 2)),
                     16'($urandom_range(0, 63)), 2'($urandom), "R11");
            end else begin
                step(c, 2'($urandom), 0, 0, 0, 2'($urandom), m_mode ? "R2" : "R1");
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule